// File: doc/BRIEF.md
# Receive Buffer Credit Tracker

This block sits on the host side of a card-style link and decides how many bytes the host may push into the peripheral's receive FIFO. The peripheral reports how many receive buffers it has ever made available as a 12-bit field inside a 32-bit status word. Whenever the host reads that word, the block captures the field. It also keeps its own count of the buffers the host has already filled. The difference, taken modulo 4096, gives the number of free buffers. Multiplied by the fixed buffer size, that number is the byte allowance.

A write engine offers a request with a byte length and waits for a grant. If the allowance is strictly greater than the length, the block grants the request and then holds off further requests until the engine signals that the transfer has finished. At that point the buffers consumed are added to the used count, and a partly filled last buffer counts as a whole one. If the allowance is too small, the block raises a re-poll request instead, so the engine reads the status word again and retries.

The buffer size is a power of two fixed at build time, given as its base-2 logarithm.

Top module: `rx_credit_tracker`

## Requirements
- R1: When `rd_valid` is high at a clock edge, bits 27 down to 16 of `rd_data` become the token count. The other bits of `rd_data` have no effect. The new count is reflected on `remaining` after that edge. This happens in either state.
- R2: `remaining` equals the token count minus the used-buffer count, modulo 4096. This holds even when the token count is numerically smaller than the used count.
- R3: `allowance` equals `remaining` multiplied by the buffer size of 2^BUF_LOG2 bytes.
- R4: While idle, `req_grant` is high in the same cycle as `req_valid` exactly when `allowance` is strictly greater than `req_len`. A request is accepted at the clock edge where `req_grant` is high.
- R5: While idle with `req_valid` high and `allowance` not greater than `req_len`, `repoll` is high and `req_grant` is low. `repoll` is never high without `req_valid`, and `repoll` and `req_grant` are never high together.
- R6: From the edge that accepts a request until the edge that samples `xfer_done`, both `req_grant` and `repoll` stay low whatever `req_valid` and `req_len` do.
- R7: When `xfer_done` is sampled after an accepted request, the used count grows by ceil(L / 2^BUF_LOG2), where L is the accepted length. A length of 0 consumes no buffer. The result appears on `remaining` after that edge, and the block returns to idle.
- R8: `xfer_done` while idle has no effect on `remaining`.
- R9: After reset the token and used counts are 0, so `remaining` and `allowance` are 0, and `req_grant` and `repoll` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_data | input | DATA_W (32) | Status word returned by a register read |
| rd_valid | input | 1 | `rd_data` holds a fresh status word |
| req_valid | input | 1 | Write engine offers a transfer |
| req_len | input | LEN_W (16) | Byte length of the offered transfer |
| req_grant | output | 1 | Transfer may proceed |
| repoll | output | 1 | Allowance too small, read the status word again |
| xfer_done | input | 1 | Granted transfer has completed |
| remaining | output | CNT_W (12) | Free buffers, modulo 2^CNT_W |
| allowance | output | CNT_W+BUF_LOG2 | Free bytes |

## Verification
The bench runs with 4-byte buffers and 8-bit lengths. With a token count of 5 it sweeps every length from 0 to 40, which shows whether the grant boundary sits at 20 as a strict comparison or one byte off. A zero token checks that every length, including 0, leads to a re-poll. A write sweep over lengths 0 to 40 tests the rounding-up of buffers used: exact multiples, one byte past a multiple, and zero length each give a different increment. Loading a token smaller than the accumulated used count tests the modulo wrap. Status words with all unrelated bits set test that only the token field is captured.

// File: rtl/rx_credit_pkg.sv
// Shared types for the receive buffer credit tracker.
package rx_credit_pkg;

    // Handshake state: waiting for a request, or a granted transfer in flight.
    typedef enum logic {
        CR_IDLE = 1'b0,
        CR_BUSY = 1'b1
    } cr_state_t;

endpackage

// File: rtl/token_capture.sv
// Captures the token field from a status word whenever a read returns.
// Assumes the field lies at TOKEN_LSB up to TOKEN_LSB+CNT_W-1 inside DATA_W.
module token_capture #(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 12,
    parameter int TOKEN_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_valid,
    output logic [CNT_W-1:0]  token
);

    localparam int TOKEN_MSB = TOKEN_LSB + CNT_W - 1;

    // Register the token field on each valid read; other bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            token <= '0;
        end else if (rd_valid) begin
            token <= rd_data[TOKEN_MSB:TOKEN_LSB];
        end
    end

    AST_TOKEN_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> token == $past(rd_data[TOKEN_MSB:TOKEN_LSB])); // R1

endmodule

// File: rtl/used_counter.sv
// Running count of receive buffers filled by the host, modulo 2^CNT_W.
// Assumes the buffer size is 2^BUF_LOG2 bytes; a partial tail buffer counts as whole.
module used_counter #(
    parameter int CNT_W    = 12,
    parameter int LEN_W    = 16,
    parameter int BUF_LOG2 = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [LEN_W-1:0] add_len,
    output logic [CNT_W-1:0] used
);

    localparam int SUM_W = LEN_W + 1;

    logic [CNT_W-1:0] inc;

    // Pick the rounding-up path, or a plain copy for one-byte buffers.
    generate
        if (BUF_LOG2 == 0) begin : g_unit_buf
            assign inc = CNT_W'(add_len);
        end else begin : g_pow2_buf
            localparam logic [SUM_W-1:0] ROUND = SUM_W'((1 << BUF_LOG2) - 1);
            logic [SUM_W-1:0] sum;
            logic [SUM_W-1:0] bufs;
            // Ceiling division by the buffer size through add-then-shift.
            always_comb begin
                sum  = SUM_W'(add_len) + ROUND;
                bufs = sum >> BUF_LOG2;
            end
            assign inc = CNT_W'(bufs);
        end
    endgenerate

    // Accumulate the buffers of each completed transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
        end else if (add_en) begin
            used <= used + inc;
        end
    end

    AST_USED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !add_en |=> used == $past(used)); // R8

endmodule

// File: rtl/credit_calc.sv
// Combinational credit arithmetic: free buffers, byte allowance, fit test.
// Assumes modulo 2^CNT_W subtraction and a strict greater-than rule for a fit.
module credit_calc #(
    parameter int CNT_W    = 12,
    parameter int LEN_W    = 16,
    parameter int BUF_LOG2 = 9,
    localparam int ALW_W   = CNT_W + BUF_LOG2
) (
    input  logic [CNT_W-1:0] token,
    input  logic [CNT_W-1:0] used,
    input  logic [LEN_W-1:0] req_len,
    output logic [CNT_W-1:0] remaining,
    output logic [ALW_W-1:0] allowance,
    output logic             fits
);

    localparam int CMP_W = (ALW_W > LEN_W) ? ALW_W : LEN_W;

    // Free buffers, byte allowance and strict comparison against the request.
    always_comb begin
        remaining = token - used;
        allowance = ALW_W'(remaining) << BUF_LOG2;
        fits      = CMP_W'(req_len) < CMP_W'(allowance);
    end

endmodule

// File: rtl/rx_credit_tracker.sv
// Top of the receive buffer credit tracker. Grants a write only when the
// byte allowance exceeds its length, then waits for completion before
// charging the used buffers. Assumes one transfer in flight at a time.
module rx_credit_tracker
    import rx_credit_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 12,
    parameter int TOKEN_LSB = 16,
    parameter int LEN_W     = 16,
    parameter int BUF_LOG2  = 9,
    localparam int ALW_W    = CNT_W + BUF_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_valid,
    input  logic              req_valid,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_grant,
    output logic              repoll,
    input  logic              xfer_done,
    output logic [CNT_W-1:0]  remaining,
    output logic [ALW_W-1:0]  allowance
);

    cr_state_t        state;
    logic [LEN_W-1:0] held_len;
    logic [CNT_W-1:0] token;
    logic [CNT_W-1:0] used;
    logic             fits;
    logic             charge;

    token_capture #(
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .TOKEN_LSB(TOKEN_LSB)
    ) i_token (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_data (rd_data),
        .rd_valid(rd_valid),
        .token   (token)
    );

    used_counter #(
        .CNT_W   (CNT_W),
        .LEN_W   (LEN_W),
        .BUF_LOG2(BUF_LOG2)
    ) i_used (
        .clk    (clk),
        .rst_n  (rst_n),
        .add_en (charge),
        .add_len(held_len),
        .used   (used)
    );

    credit_calc #(
        .CNT_W   (CNT_W),
        .LEN_W   (LEN_W),
        .BUF_LOG2(BUF_LOG2)
    ) i_calc (
        .token    (token),
        .used     (used),
        .req_len  (req_len),
        .remaining(remaining),
        .allowance(allowance),
        .fits     (fits)
    );

    // Handshake outputs: grant on a fit, re-poll otherwise, both only when idle.
    always_comb begin
        req_grant = req_valid && (state == CR_IDLE) && fits;
        repoll    = req_valid && (state == CR_IDLE) && !fits;
        charge    = (state == CR_BUSY) && xfer_done;
    end

    // Track the transfer in flight and remember its length for charging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CR_IDLE;
            held_len <= '0;
        end else begin
            case (state)
                CR_IDLE: if (req_grant) begin
                    state    <= CR_BUSY;
                    held_len <= req_len;
                end
                CR_BUSY: if (xfer_done) begin
                    state <= CR_IDLE;
                end
                default: state <= CR_IDLE;
            endcase
        end
    end

    AST_GRANT_REPOLL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_grant && repoll)); // R5
    AST_REPOLL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        repoll |-> req_valid); // R5
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        req_grant |=> !req_grant && !repoll); // R6

endmodule

// File: tb/test_rx_credit_tracker.sv
`timescale 1ns/1ps
module test_rx_credit_tracker;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 12;
    localparam int LSB    = 16;
    localparam int LEN_W  = 8;
    localparam int BL2    = 2;
    localparam int BUFB   = 1 << BL2;
    localparam int ALW_W  = CNT_W + BL2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] rd_data = '0;
    logic              rd_valid = 1'b0;
    logic              req_valid = 1'b0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_grant;
    logic              repoll;
    logic              xfer_done = 1'b0;
    logic [CNT_W-1:0]  remaining;
    logic [ALW_W-1:0]  allowance;

    int n_checks = 0;
    int n_fail   = 0;
    int tok      = 0;
    int used     = 0;

    always #2 clk = ~clk;

    rx_credit_tracker #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .TOKEN_LSB(LSB),
        .LEN_W(LEN_W), .BUF_LOG2(BL2)
    ) i_rx_credit_tracker (
        .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .rd_valid(rd_valid),
        .req_valid(req_valid), .req_len(req_len), .req_grant(req_grant),
        .repoll(repoll), .xfer_done(xfer_done), .remaining(remaining),
        .allowance(allowance)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_rem();
        return (tok - used) & ((1 << CNT_W) - 1);
    endfunction

    // Present a status word for one edge; junk fills every non-token bit.
    task automatic load_token(input int t, input logic junk);
        @(negedge clk);
        rd_data  = junk ? 32'hFFFF_FFFF : 32'h0;
        rd_data[LSB +: CNT_W] = CNT_W'(t);
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        rd_data  = '0;
        tok = t;
        #1;
        chk("R1 token capture", int'(remaining), exp_rem());
        chk("R3 allowance", int'(allowance), exp_rem() * BUFB);
    endtask

    // Offer a length without letting it reach an edge; check the decision.
    task automatic probe(input int len);
        @(negedge clk);
        req_valid = 1'b1;
        req_len   = LEN_W'(len);
        #1;
        chk($sformatf("R4 grant len=%0d", len), int'(req_grant),
            int'(exp_rem() * BUFB > len));
        chk($sformatf("R5 repoll len=%0d", len), int'(repoll),
            int'(exp_rem() * BUFB <= len));
        req_valid = 1'b0;
    endtask

    // Full granted write, with a busy-phase probe and completion.
    task automatic do_write(input int len);
        @(negedge clk);
        req_valid = 1'b1;
        req_len   = LEN_W'(len);
        #1;
        chk("R4 write grant", int'(req_grant), 1);
        @(negedge clk);
        req_len = 8'd0;
        #0.5;
        chk("R6 busy no grant", int'(req_grant), 0);
        chk("R6 busy no repoll", int'(repoll), 0);
        req_valid = 1'b0;
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        used = used + (len + BUFB - 1) / BUFB;
        #1;
        chk($sformatf("R7 charge len=%0d", len), int'(remaining), exp_rem());
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset remaining", int'(remaining), 0);
        chk("R9 reset allowance", int'(allowance), 0);
        chk("R9 reset grant", int'(req_grant), 0);
        chk("R9 reset repoll", int'(repoll), 0);
        rst_n = 1'b1;

        probe(0);
        load_token(5, 1'b1);
        for (int l = 0; l <= 40; l++) probe(l);
        load_token(0, 1'b0);
        for (int l = 0; l <= 8; l++) probe(l);

        load_token(4095, 1'b1);
        for (int l = 0; l <= 40; l++) do_write(l);

        // R8: completion strobe while idle leaves the count alone.
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        #1;
        chk("R8 idle done ignored", int'(remaining), exp_rem());

        // R2: token below used count wraps modulo 4096.
        load_token(7, 1'b0);
        chk("R2 wrap remaining", int'(remaining), (7 - used) & 4095);
        for (int l = 250; l <= 255; l++) probe(l);

        // R1: token reload while a transfer is in flight.
        @(negedge clk);
        req_valid = 1'b1;
        req_len   = 8'd3;
        @(negedge clk);
        req_valid = 1'b0;
        rd_data   = 32'h0000_0000;
        rd_data[LSB +: CNT_W] = 12'd300;
        rd_valid  = 1'b1;
        @(negedge clk);
        rd_valid  = 1'b0;
        tok = 300;
        #1;
        chk("R1 reload while busy", int'(remaining), exp_rem());
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        used = used + 1;
        #1;
        chk("R7 charge after reload", int'(remaining), exp_rem());

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule